// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the software-facing register file of an interrupt router. Software sees three locations in a 256-byte window: a selector that holds an 8-bit register index, a data window that reads or writes the register the selector points at, and a direct end-of-interrupt location. Through the selector and window, software reaches an identification register, a read-only version register, an arbitration register, and one 64-bit routing entry per input pin. Each entry is reached one 32-bit half at a time.

The entry table is presented flat to the delivery engine. The engine owns two status bits in every entry: the delivery-busy flag and the remote in-service flag. Software cannot write either bit. After every accepted entry write, the block requests one service pass from the engine. A word write to the end-of-interrupt location produces a one-cycle broadcast strobe carrying the written vector, but only when the block is built with version 0x20.

The block has one port in each direction, with single-cycle access. Read data is combinational in the request cycle. All state changes take effect at the clock edge that ends the request cycle. The two strobes, `svc_o` and `eoi_o`, are high during the following cycle.

Top module: `irq_regwin`

## Requirements
- R1: After reset, the selector, the stored ID, every entry and both strobes are zero.
- R2: Only `addr_i[7:0]` is decoded. Offset 0x00 is the selector. It accepts writes of any size, keeping `wdata_i[7:0]`, and reads back as the current index in bits [7:0].
- R3: Window accesses (offset 0x10) and end-of-interrupt writes (offset 0x40) take effect only when `size_i` is 2 (32-bit). Sizes 0 and 1 are 8-bit and 16-bit. A narrower window read returns 0, and a narrower write changes nothing.
- R4: Index 0 and index 2 both read as the 4-bit stored ID in bits [27:24], with all other bits zero. A word write to index 0 stores `wdata_i[27:24]`. Writes to index 1 and index 2 are discarded.
- R5: Index 1 reads as `VERSION` in bits [7:0] and `PINS-1` in bits [23:16], with all other bits zero.
- R6: Index 0x10 and above select entry n = (index-0x10)>>1. An even index selects bits [31:0] of the entry and an odd index selects bits [63:32]. Entry n appears on `tbl_o[64n+63:64n]`.
- R7: An entry write never changes bit 12 (delivery busy) or bit 14 (remote in-service); all other bits take the written data. Bit 12 follows `dstat_i[n]` one cycle later. Bit 14 is set by `rirr_set_i[n]` and cleared by `rirr_clr_i[n]`, and set wins when both are high.
- R8: After an entry write, if the resulting bit 15 is 0 (edge trigger), bit 14 is zero. This holds even when the engine sets the bit in the same cycle.
- R9: `svc_o` is high for exactly the cycle after each accepted entry write (either half). Selector writes, ID writes and ignored writes do not raise it.
- R10: A word write to offset 0x40 with `VERSION` 0x20 makes `eoi_o` high for one cycle, with `eoi_vec_o` equal to `wdata_i[7:0]`. With `VERSION` 0x11 the write has no effect.
- R11: Indices 3 to 0x0F, and entry indices whose entry number is not below `PINS`, read as 0. Writes to them change no entry and raise no strobe.
- R12: When an entry write in level mode (bit 15 = 1) and `rirr_set_i[n]` fall in the same cycle, bit 14 ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address, only the low 8 bits are decoded |
| size_i | input | 2 | Access size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| dstat_i | input | PINS | Delivery-busy level per entry, from the engine |
| rirr_set_i | input | PINS | Set remote in-service per entry |
| rirr_clr_i | input | PINS | Clear remote in-service per entry |
| tbl_o | output | 64*PINS | Flattened entry table |
| svc_o | output | 1 | Service-pass request after an entry write |
| eoi_o | output | 1 | End-of-interrupt broadcast strobe |
| eoi_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
Two functions can fall in the same cycle: a software write to an entry, and the engine's update of that entry's remote in-service bit.

The bench provokes this by holding `rirr_set_i` (and, in another case, `rirr_clr_i` together with it) during the exact cycle of the window write. It does this once with a level-mode value and once with an edge-mode value. The result is judged from bit 14, read back through the window and on `tbl_o`:
- the level-mode write must leave the bit set;
- the edge-mode write must leave it clear.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h40;

  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] IDX_ENT0 = 8'h10;

  localparam int ID_LSB  = 24;
  localparam int ID_W    = 4;
  localparam int B_DSTAT = 12;
  localparam int B_RIRR  = 14;
  localparam int B_TRIG  = 15;

  // engine-owned bits in the low half of an entry
  localparam logic [31:0] RO_LO = (32'h1 << B_DSTAT) | (32'h1 << B_RIRR);
endpackage

// File: rtl/irqw_decode.sv
module irqw_decode
  import irqw_pkg::*;
#(
  parameter int PINS = 24,
  parameter int IW   = 5
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [7:0]    off_i,
  input  logic [1:0]    size_i,
  input  logic [7:0]    sel_i,
  output logic          sel_wr_o,
  output logic          win_rd_o,
  output logic          id_wr_o,
  output logic          eoi_wr_o,
  output logic          is_id_o,
  output logic          is_ver_o,
  output logic          ent_hit_o,
  output logic          ent_hi_o,
  output logic          ent_wr_o,
  output logic [IW-1:0] ent_idx_o
);
  localparam logic [7:0] PINS8 = 8'(PINS);

  logic       word;
  logic       win;
  logic [7:0] rel;
  logic [6:0] ent_num;

  always_comb begin
    word      = (size_i == SZ_WORD);
    win       = req_i && (off_i == OFF_WIN) && word;
    sel_wr_o  = req_i && we_i && (off_i == OFF_SEL);
    win_rd_o  = win && !we_i;
    eoi_wr_o  = req_i && we_i && word && (off_i == OFF_EOI);
    is_id_o   = (sel_i == IDX_ID) || (sel_i == IDX_ARB);
    is_ver_o  = (sel_i == IDX_VER);
    id_wr_o   = win && we_i && (sel_i == IDX_ID);
    rel       = sel_i - IDX_ENT0;
    ent_num   = rel[7:1];
    ent_hit_o = (sel_i >= IDX_ENT0) && ({1'b0, ent_num} < PINS8);
    ent_hi_o  = sel_i[0];
    ent_idx_o = ent_num[IW-1:0];
    ent_wr_o  = win && we_i && ent_hit_o;
  end
endmodule

// File: rtl/irqw_entry.sv
module irqw_entry
  import irqw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        dstat_i,
  input  logic        rset_i,
  input  logic        rclr_i,
  output logic [63:0] q_o
);
  logic [63:0] q, nxt;

  always_comb begin
    nxt = q;
    if (wr_lo_i) nxt[31:0]  = (wdata_i & ~RO_LO) | (q[31:0] & RO_LO);
    if (wr_hi_i) nxt[63:32] = wdata_i;
    nxt[B_DSTAT] = dstat_i;
    nxt[B_RIRR]  = rset_i | (q[B_RIRR] & ~rclr_i);
    // edge-mode entry written: remote in-service must read zero
    if ((wr_lo_i || wr_hi_i) && !nxt[B_TRIG]) nxt[B_RIRR] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o = q;

  a_r8_edge_clears_remote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i || wr_hi_i) |=> (q_o[B_TRIG] || !q_o[B_RIRR]));

  a_r7_hi_write_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> (q_o[11:0] == $past(q_o[11:0])));

  a_r7_dstat_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dstat_i |=> q_o[B_DSTAT]);

  a_r12_set_wins_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rset_i && !(wr_lo_i && !wdata_i[B_TRIG]) && !(wr_hi_i && !q_o[B_TRIG]))
      |=> q_o[B_RIRR]);
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import irqw_pkg::*;
#(
  parameter int          PINS    = 24,
  parameter int          ADDR_W  = 12,
  parameter logic [7:0]  VERSION = 8'h20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [PINS-1:0]      dstat_i,
  input  logic [PINS-1:0]      rirr_set_i,
  input  logic [PINS-1:0]      rirr_clr_i,
  output logic [64*PINS-1:0]   tbl_o,
  output logic                 svc_o,
  output logic                 eoi_o,
  output logic [7:0]           eoi_vec_o
);
  localparam int          IW       = (PINS > 1) ? $clog2(PINS) : 1;
  localparam logic        EOI_EN   = (VERSION == 8'h20);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(PINS - 1), 8'h00, VERSION};

  if (!(VERSION == 8'h11 || VERSION == 8'h20)) begin : g_bad_version
    $error("irq_regwin: VERSION must be 0x11 or 0x20");
  end
  if (PINS < 2 || PINS > 120) begin : g_bad_pins
    $error("irq_regwin: PINS must be 2..120");
  end

  logic [7:0]      sel_q;
  logic [ID_W-1:0] id_q;
  logic            svc_q, eoi_q;
  logic [7:0]      vec_q;

  logic          sel_wr, win_rd, id_wr, eoi_wr, is_id, is_ver;
  logic          ent_hit, ent_hi, ent_wr;
  logic [IW-1:0] ent_idx;
  logic [63:0]   ent_q [PINS];

  irqw_decode #(.PINS(PINS), .IW(IW)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .off_i    (addr_i[7:0]),
    .size_i   (size_i),
    .sel_i    (sel_q),
    .sel_wr_o (sel_wr),
    .win_rd_o (win_rd),
    .id_wr_o  (id_wr),
    .eoi_wr_o (eoi_wr),
    .is_id_o  (is_id),
    .is_ver_o (is_ver),
    .ent_hit_o(ent_hit),
    .ent_hi_o (ent_hi),
    .ent_wr_o (ent_wr),
    .ent_idx_o(ent_idx)
  );

  for (genvar g = 0; g < PINS; g++) begin : g_ent
    logic hit;
    assign hit = ent_wr && (ent_idx == IW'(g));
    irqw_entry u_ent (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_lo_i(hit && !ent_hi),
      .wr_hi_i(hit && ent_hi),
      .wdata_i(wdata_i),
      .dstat_i(dstat_i[g]),
      .rset_i (rirr_set_i[g]),
      .rclr_i (rirr_clr_i[g]),
      .q_o    (ent_q[g])
    );
    assign tbl_o[g*64 +: 64] = ent_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
      svc_q <= 1'b0;
      eoi_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (sel_wr) sel_q <= wdata_i[7:0];
      if (id_wr)  id_q  <= wdata_i[ID_LSB +: ID_W];
      svc_q <= ent_wr;
      eoi_q <= eoi_wr && EOI_EN;
      if (eoi_wr && EOI_EN) vec_q <= wdata_i[7:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (addr_i[7:0] == OFF_SEL) begin
        rdata_o = {24'h0, sel_q};
      end else if (win_rd) begin
        if (is_id)        rdata_o = {4'h0, id_q, 24'h0};
        else if (is_ver)  rdata_o = VER_WORD;
        else if (ent_hit) rdata_o = ent_hi ? ent_q[ent_idx][63:32] : ent_q[ent_idx][31:0];
      end
    end
  end

  assign svc_o     = svc_q;
  assign eoi_o     = eoi_q;
  assign eoi_vec_o = vec_q;

  a_r9_svc_after_entry_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |-> $past(ent_wr));

  a_r10_eoi_after_eoi_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> $past(eoi_wr));

  a_r4_id_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_wr |=> $stable(id_q));

  a_r3_narrow_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i != SZ_WORD && addr_i[7:0] != OFF_SEL) |-> (rdata_o == 32'h0));
endmodule

// File: tb/irq_regwin_test.sv
`timescale 1ns/1ps
module irq_regwin_test;
  localparam int PINS = 24;
  localparam logic [1:0] SB = 2'd0, SH = 2'd1, SW = 2'd2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req = 1'b0, we = 1'b0;
  logic [11:0]        addr = '0;
  logic [1:0]         size = SW;
  logic [31:0]        wdata = '0;
  logic [PINS-1:0]    dstat = '0, rset = '0, rclr = '0;
  logic [31:0]        rdata, rdata11;
  logic [64*PINS-1:0] tbl, tbl11;
  logic               svc, eoi, svc11, eoi11;
  logic [7:0]         vec, vec11;

  int nchk = 0, nfail = 0;
  logic cap_svc, cap_eoi, cap_eoi11;
  logic [7:0] cap_vec;

  always #2 clk = ~clk;

  irq_regwin #(.PINS(PINS), .ADDR_W(12), .VERSION(8'h20)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rdata_o(rdata), .dstat_i(dstat), .rirr_set_i(rset), .rirr_clr_i(rclr),
    .tbl_o(tbl), .svc_o(svc), .eoi_o(eoi), .eoi_vec_o(vec));

  irq_regwin #(.PINS(PINS), .ADDR_W(12), .VERSION(8'h11)) uut_v11 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rdata_o(rdata11), .dstat_i(dstat), .rirr_set_i(rset), .rirr_clr_i(rclr),
    .tbl_o(tbl11), .svc_o(svc11), .eoi_o(eoi11), .eoi_vec_o(vec11));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] s, input logic [31:0] d,
                    input logic [PINS-1:0] setm = '0, input logic [PINS-1:0] clrm = '0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; size = s; wdata = d; rset = setm; rclr = clrm;
    @(negedge clk);
    req = 1'b0; we = 1'b0; rset = '0; rclr = '0;
    cap_svc = svc; cap_eoi = eoi; cap_eoi11 = eoi11; cap_vec = vec;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] s,
                    output logic [31:0] v, output logic [31:0] v11);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; size = s;
    #1;
    v = rdata; v11 = rdata11;
    req = 1'b0;
  endtask

  task automatic wr_ent(input int n, input bit hi, input logic [31:0] d,
                        input logic [PINS-1:0] setm = '0, input logic [PINS-1:0] clrm = '0);
    wr(12'h000, SW, 32'(8'h10 + 2*n + int'(hi)));
    wr(12'h010, SW, d, setm, clrm);
  endtask

  task automatic rd_ent(input int n, input bit hi, output logic [31:0] v);
    logic [31:0] v11;
    wr(12'h000, SW, 32'(8'h10 + 2*n + int'(hi)));
    rd(12'h010, SW, v, v11);
  endtask

  task automatic t_reset();
    logic [31:0] v, v11;
    chk("R1 table zero", 64'(tbl == '0), 64'd1);
    chk("R1 strobes zero", {62'd0, svc, eoi}, 64'd0);
    rd(12'h000, SW, v, v11);
    chk("R1 selector zero", 64'(v), 64'd0);
  endtask

  task automatic t_selector();
    logic [31:0] v, v11;
    wr(12'hF00, SB, 32'hFFFF_FF23);
    chk("R9 no svc on selector write", 64'(cap_svc), 64'd0);
    rd(12'h100, SW, v, v11);
    chk("R2 selector via aliased address", 64'(v), 64'h23);
  endtask

  task automatic t_id_version();
    logic [31:0] v, v11;
    wr(12'h000, SW, 32'h0);
    wr(12'h010, SW, 32'hA5FF_FFFF);
    chk("R9 no svc on id write", 64'(cap_svc), 64'd0);
    rd(12'h010, SW, v, v11);
    chk("R4 id read at index 0", 64'(v), 64'h0500_0000);
    wr(12'h000, SW, 32'h2);
    rd(12'h010, SW, v, v11);
    chk("R4 id read at index 2", 64'(v), 64'h0500_0000);
    wr(12'h010, SW, 32'h0F00_0000);
    wr(12'h000, SW, 32'h1);
    wr(12'h010, SW, 32'hFFFF_FFFF);
    rd(12'h010, SW, v, v11);
    chk("R5 version word v20", 64'(v), 64'h0017_0020);
    chk("R5 version word v11", 64'(v11), 64'h0017_0011);
    wr(12'h000, SW, 32'h0);
    rd(12'h010, SW, v, v11);
    chk("R4 index 2 write discarded", 64'(v), 64'h0500_0000);
  endtask

  task automatic t_entry_map();
    logic [31:0] v, v11;
    wr_ent(3, 1'b0, 32'h0000_8031);
    chk("R9 svc after low-half write", 64'(cap_svc), 64'd1);
    wr_ent(3, 1'b1, 32'hAB00_0000);
    chk("R9 svc after high-half write", 64'(cap_svc), 64'd1);
    chk("R6 entry 3 on table", tbl[3*64 +: 64], 64'hAB00_0000_0000_8031);
    rd(12'h010, SW, v, v11);
    chk("R6 odd index reads high half", 64'(v), 64'hAB00_0000);
    rd_ent(3, 1'b0, v);
    chk("R6 even index reads low half", 64'(v), 64'h0000_8031);
  endtask

  task automatic t_size();
    logic [31:0] v, v11;
    wr(12'h000, SW, 32'h16);
    wr(12'h010, SB, 32'hFFFF_FFFF);
    chk("R3 byte window write ignored", tbl[3*64 +: 64], 64'hAB00_0000_0000_8031);
    chk("R3 no svc on ignored write", 64'(cap_svc), 64'd0);
    rd(12'h010, SH, v, v11);
    chk("R3 half window read zero", 64'(v), 64'd0);
    wr(12'h040, SH, 32'h55);
    chk("R3 half eoi write ignored", 64'(cap_eoi), 64'd0);
  endtask

  task automatic t_ro_bits();
    logic [31:0] v;
    wr_ent(5, 1'b0, 32'h0000_8000);
    @(negedge clk); rset[5] = 1'b1;
    @(negedge clk); rset[5] = 1'b0;
    chk("R7 engine sets remote", 64'(tbl[5*64 + 14]), 64'd1);
    wr_ent(5, 1'b0, 32'hFFFF_FFFF);
    chk("R7 read-only bits kept", 64'(tbl[5*64 +: 32]), 64'hFFFF_EFFF);
    @(negedge clk); dstat[5] = 1'b1;
    @(negedge clk);
    rd_ent(5, 1'b0, v);
    chk("R7 busy bit follows engine", 64'(v), 64'hFFFF_FFFF);
    dstat[5] = 1'b0;
    wr_ent(5, 1'b0, 32'h0000_0000 | 32'h8000);
    @(negedge clk); rclr[5] = 1'b1;
    @(negedge clk); rclr[5] = 1'b0;
    chk("R7 engine clears remote", 64'(tbl[5*64 + 14]), 64'd0);
  endtask

  task automatic t_edge();
    wr_ent(6, 1'b0, 32'h0000_8000);
    @(negedge clk); rset[6] = 1'b1;
    @(negedge clk); rset[6] = 1'b0;
    wr_ent(6, 1'b0, 32'h0000_4030);
    chk("R8 edge write zeroes remote", 64'(tbl[6*64 +: 32]), 64'h0000_0030);
    wr_ent(6, 1'b1, 32'h1100_0000, 24'(1) << 6);
    chk("R8 high write on edge entry keeps remote zero", tbl[6*64 +: 64], 64'h1100_0000_0000_0030);
  endtask

  task automatic t_collision();
    wr_ent(7, 1'b0, 32'h0000_8040);
    wr_ent(7, 1'b0, 32'h0000_8041, 24'(1) << 7);
    chk("R12 level write with same-cycle set", 64'(tbl[7*64 +: 32]), 64'h0000_C041);
    @(negedge clk); rset[7] = 1'b1; rclr[7] = 1'b1;
    @(negedge clk); rset[7] = 1'b0; rclr[7] = 1'b0;
    chk("R7 set wins over clear", 64'(tbl[7*64 + 14]), 64'd1);
    wr_ent(7, 1'b0, 32'h0000_0041, 24'(1) << 7);
    chk("R8 edge write with same-cycle set", 64'(tbl[7*64 +: 32]), 64'h0000_0041);
  endtask

  task automatic t_eoi();
    wr(12'hA40, SW, 32'h0000_0137);
    chk("R10 eoi strobe v20", 64'(cap_eoi), 64'd1);
    chk("R10 eoi vector", 64'(cap_vec), 64'h37);
    chk("R10 no eoi for v11", 64'(cap_eoi11), 64'd0);
    @(negedge clk);
    chk("R10 eoi one cycle", 64'(eoi), 64'd0);
  endtask

  task automatic t_range();
    logic [31:0] v, v11;
    logic [64*PINS-1:0] snap;
    snap = tbl;
    wr(12'h000, SW, 32'h40);
    rd(12'h010, SW, v, v11);
    chk("R11 out-of-range entry reads zero", 64'(v), 64'd0);
    wr(12'h010, SW, 32'hDEAD_BEEF);
    chk("R11 out-of-range write no svc", 64'(cap_svc), 64'd0);
    chk("R11 table unchanged", 64'(tbl == snap), 64'd1);
    wr(12'h000, SW, 32'h05);
    rd(12'h010, SW, v, v11);
    chk("R11 reserved index reads zero", 64'(v), 64'd0);
  endtask

  initial begin
    #4000000;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_selector();
    t_id_version();
    t_entry_map();
    t_size();
    t_ro_bits();
    t_edge();
    t_collision();
    t_eoi();
    t_range();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule